// File: doc/BRIEF.md
# Fully-Associative Cache Tag Tracker

This block models the tag side of a small fully-associative cache. It classifies a stream of byte-address references as hits or misses, and it does not store any data. Each valid reference is compared against every stored line tag in parallel. On a hit, the matching line becomes the most recently used line. On a miss, the new tag is installed in the same cycle. The block first fills an empty line, taking the lowest-numbered one. When no line is empty, it replaces the least recently used line. A full recency stack keeps the exact use order of all lines.

The response is registered and appears one cycle after the request strobe. It gives a hit flag and the index of the line that was used. Two saturating counters total the hits and the misses. A synchronous clear returns the block to its empty state without pulsing the reset. The block is meant for performance-model checks and for trace-driven tag studies that sit beside a larger memory subsystem.

Top module: `fa_tag_tracker`

## Requirements
- R1: After the asynchronous reset, every line is invalid, `rsp_valid_o` is low, and both counters read zero.
- R2: A line covers 8 bytes, so the tag is `req_addr_i` shifted right by 3. Any two addresses that differ only in bits [2:0] map to the same line, and the second of two such consecutive accesses is a hit.
- R3: `rsp_hit_o` is high only when a valid line holds the requested tag. A stored tag of zero on an invalid line never hits, so address 0 misses right after reset.
- R4: While any line is invalid, a miss fills the lowest-numbered invalid line. From empty, misses therefore fill lines 0, 1, 2 and 3 in that order.
- R5: When all four lines are valid, a miss replaces the least recently used line and reports that line's index.
- R6: A hit and a fill both move the touched line to the most-recently-used position. All other lines keep their relative order.
- R7: A request sampled with `req_valid_i` high and `clear_i` low gives `rsp_valid_o` high on the next cycle, with `rsp_hit_o` and `rsp_line_o` for that request. In every other cycle `rsp_valid_o` is low.
- R8: Each hit adds one to `hit_cnt_o` and each miss adds one to `miss_cnt_o`. Both counters are 16 bits wide and hold at 65535 instead of wrapping.
- R9: `clear_i` is synchronous. It invalidates all lines, restores the recency order, zeroes both counters and suppresses the response. It overrides a request in the same cycle.
- R10: When `req_valid_i` is low, no line, recency order or counter changes, whatever the value on `req_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of lines, recency order and counters |
| req_valid_i | input | 1 | Reference strobe |
| req_addr_i | input | 32 | Byte address of the reference |
| rsp_valid_o | output | 1 | Result valid, one cycle after the strobe |
| rsp_hit_o | output | 1 | 1 for a hit, 0 for a miss |
| rsp_line_o | output | 2 | Index of the line hit or filled |
| hit_cnt_o | output | 16 | Saturating hit count |
| miss_cnt_o | output | 16 | Saturating miss count |

## Verification
The assertions assume that `req_addr_i` is a stable, known value whenever `req_valid_i` is sampled high. They also assume that a clear and a request are judged only by their values at the clock edge, with `clear_i` taking priority.

The fill-order check keeps its own count of fills since the last clear. That count is only meaningful when every miss is reported, so the stimulus never aborts a response.

The bench changes its inputs only on falling edges. It uses the simultaneous clear-and-request case to exercise clear priority on purpose. It leaves `req_addr_i` pointing at a resident line during idle cycles, so an idle cycle that wrongly updated the state would show up in the counters or the recency order.

// File: rtl/ft_pkg.sv
package ft_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_HIT   = 2'd1,
    ACC_FILL  = 2'd2,
    ACC_EVICT = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/ft_tag_array.sv
module ft_tag_array #(
  parameter int LINES = 4,
  parameter int TAG_W = 29,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [TAG_W-1:0] lookup_tag_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic             free_o,
  output logic [IDX_W-1:0] free_idx_o
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] match;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (clear_i) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= lookup_tag_i;
      end
    end
    assign match[g] = valid_q[g] && (tag_q[g] == lookup_tag_i);
  end

  // lowest index wins for both encoders
  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i])    hit_idx_o  = IDX_W'(i);
      if (!valid_q[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign hit_o  = |match;
  assign free_o = ~&valid_q;
endmodule

// File: rtl/ft_lru_stack.sv
module ft_lru_stack #(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);
  // order_q[0] = MRU, order_q[LINES-1] = LRU
  logic [IDX_W-1:0] order_q [LINES];
  logic [IDX_W-1:0] order_d [LINES];
  int               pos;

  always_comb begin
    pos = LINES - 1;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (order_q[i] == touch_idx_i) pos = i;
    end
    for (int i = 0; i < LINES; i++) order_d[i] = order_q[i];
    for (int i = LINES - 1; i > 0; i--) begin
      if (i <= pos) order_d[i] = order_q[i-1];
    end
    order_d[0] = touch_idx_i;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      order_q[g] <= IDX_W'(g);
      else if (clear_i) order_q[g] <= IDX_W'(g);
      else if (touch_i) order_q[g] <= order_d[g];
    end
  end

  assign lru_idx_o = order_q[LINES-1];
endmodule

// File: rtl/ft_sat_counter.sv
module ft_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     count_o <= '0;
    else if (clear_i)                count_o <= '0;
    else if (inc_i && count_o != MAX) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/fa_tag_tracker.sv
module fa_tag_tracker
  import ft_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 4,
  parameter int LINE_BYTES = 8,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [IDX_W-1:0]  rsp_line_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  logic [TAG_W-1:0] req_tag;
  logic             arr_hit, arr_free;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_idx, sel_idx;
  logic             take;
  acc_kind_e        kind;

  assign req_tag = req_addr_i[ADDR_W-1:OFF_W];
  assign take    = req_valid_i && !clear_i;

  always_comb begin
    if (!take)         kind = ACC_IDLE;
    else if (arr_hit)  kind = ACC_HIT;
    else if (arr_free) kind = ACC_FILL;
    else               kind = ACC_EVICT;
  end

  always_comb begin
    unique case (kind)
      ACC_HIT:   sel_idx = hit_idx;
      ACC_FILL:  sel_idx = free_idx;
      ACC_EVICT: sel_idx = lru_idx;
      default:   sel_idx = '0;
    endcase
  end

  ft_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni, .clear_i,
    .lookup_tag_i (req_tag),
    .wr_en_i      (kind == ACC_FILL || kind == ACC_EVICT),
    .wr_idx_i     (sel_idx),
    .hit_o        (arr_hit),
    .hit_idx_o    (hit_idx),
    .free_o       (arr_free),
    .free_idx_o   (free_idx)
  );

  ft_lru_stack #(.LINES(LINES)) u_lru (
    .clk_i, .rst_ni, .clear_i,
    .touch_i     (kind != ACC_IDLE),
    .touch_idx_i (sel_idx),
    .lru_idx_o   (lru_idx)
  );

  ft_sat_counter #(.W(CNT_W)) u_hit_cnt (
    .clk_i, .rst_ni, .clear_i,
    .inc_i   (kind == ACC_HIT),
    .count_o (hit_cnt_o)
  );

  ft_sat_counter #(.W(CNT_W)) u_miss_cnt (
    .clk_i, .rst_ni, .clear_i,
    .inc_i   (kind == ACC_FILL || kind == ACC_EVICT),
    .count_o (miss_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_line_o  <= '0;
    end else begin
      rsp_valid_o <= take;
      if (take) begin
        rsp_hit_o  <= (kind == ACC_HIT);
        rsp_line_o <= sel_idx;
      end
    end
  end
endmodule

// File: rtl/ft_tag_tracker_chk.sv
module ft_tag_tracker_chk #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 4,
  parameter int OFF_W  = 3,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [IDX_W-1:0]  rsp_line_o,
  input logic [CNT_W-1:0]  hit_cnt_o,
  input logic [CNT_W-1:0]  miss_cnt_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  logic [IDX_W:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fill_q <= '0;
    else if (clear_i) fill_q <= '0;
    else if (rsp_valid_o && !rsp_hit_o && fill_q < (IDX_W+1)'(LINES))
      fill_q <= fill_q + 1'b1;
  end

  assert_rsp_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !clear_i) |=> rsp_valid_o);
  assert_rsp_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !clear_i) |=> !rsp_valid_o);
  assert_hit_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !clear_i) |=> (rsp_hit_o ?
      (hit_cnt_o == $past(hit_cnt_o) + 1'b1 || hit_cnt_o == MAX) :
      (miss_cnt_o == $past(miss_cnt_o) + 1'b1 || miss_cnt_o == MAX)));
  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !clear_i) |=> ($stable(hit_cnt_o) && $stable(miss_cnt_o)));
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (hit_cnt_o == '0 && miss_cnt_o == '0 && !rsp_valid_o));
  assert_no_hit_after_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clear_i) && req_valid_i && !clear_i) |=> !rsp_hit_o);
  assert_same_block_hits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !clear_i && $past(req_valid_i && !clear_i) &&
     req_addr_i[ADDR_W-1:OFF_W] == $past(req_addr_i[ADDR_W-1:OFF_W])) |=> rsp_hit_o);
  assert_fill_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o && fill_q < (IDX_W+1)'(LINES)) |->
      rsp_line_o == fill_q[IDX_W-1:0]);
endmodule

bind fa_tag_tracker ft_tag_tracker_chk #(
  .ADDR_W(ADDR_W), .LINES(LINES), .OFF_W(OFF_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
  .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_line_o(rsp_line_o),
  .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
);

// File: tb/tb_fa_tag_tracker.sv
`timescale 1ns/1ps
module tb_fa_tag_tracker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        rsp_valid_o, rsp_hit_o;
  logic [1:0]  rsp_line_o;
  logic [15:0] hit_cnt_o, miss_cnt_o;

  int checks = 0;
  int fails  = 0;
  int exp_hits = 0;
  int exp_miss = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fa_tag_tracker dut (
    .clk_i, .rst_ni, .clear_i, .req_valid_i, .req_addr_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_line_o, .hit_cnt_o, .miss_cnt_o
  );

  localparam int N = 15;
  localparam int unsigned T_ADDR [N] = '{0, 4, 8, 20, 36, 96, 32, 4, 12, 16, 24, 48, 44, 8, 0};
  localparam bit          T_HIT  [N] = '{0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int unsigned T_LINE [N] = '{0, 0, 1, 2, 3, 0, 3, 1, 2, 0, 3, 1, 2, 0, 3};

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // set inputs at a falling edge, return at the next one with results visible
  task automatic step(bit v, int unsigned a, bit clr = 1'b0);
    req_valid_i = v;
    req_addr_i  = a;
    clear_i     = clr;
    @(negedge clk_i);
  endtask

  task automatic access(string req, int unsigned a, bit hit, int unsigned line);
    step(1'b1, a);
    chk({req, " rsp_valid"}, rsp_valid_o, 1);
    chk({req, " hit"}, rsp_hit_o, hit);
    chk({req, " line"}, rsp_line_o, line);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid_o, 0);
    chk("R1 hit_cnt", hit_cnt_o, 0);
    chk("R1 miss_cnt", miss_cnt_o, 0);

    // R2 R3 R4 R5 R6: reference stream from empty
    for (int i = 0; i < N; i++) begin
      access($sformatf("R2-R6 vec%0d", i), T_ADDR[i], T_HIT[i], T_LINE[i]);
      if (T_HIT[i]) exp_hits++; else exp_miss++;
      chk($sformatf("R8 vec%0d hit_cnt", i), hit_cnt_o, exp_hits);
      chk($sformatf("R8 vec%0d miss_cnt", i), miss_cnt_o, exp_miss);
    end

    // R10: idle with address of a resident block (tag 0 in line 3)
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 0);
      chk("R10 rsp_valid idle", rsp_valid_o, 0);
      chk("R10 hit_cnt idle", hit_cnt_o, 2);
      chk("R10 miss_cnt idle", miss_cnt_o, 13);
    end
    // order untouched: line0 (tag1) hit, then miss evicts line1
    access("R10 R6 hit tag1", 9, 1, 0);
    access("R5 evict after idle", 800, 0, 1);
    step(1'b0, 0);

    // R9: clear together with a request
    step(1'b1, 0, 1'b1);
    chk("R9 rsp_valid", rsp_valid_o, 0);
    chk("R9 hit_cnt", hit_cnt_o, 0);
    chk("R9 miss_cnt", miss_cnt_o, 0);
    // R3 R4: emptied, refill from line 0
    access("R3 R9 miss after clear", 0, 0, 0);
    access("R4 fill1", 64, 0, 1);
    access("R4 fill2", 128, 0, 2);
    access("R4 fill3", 192, 0, 3);
    // R6: hit line0 refreshes it, evictions skip it
    access("R6 hit line0", 7, 1, 0);
    access("R6 R5 evict1", 256, 0, 1);
    access("R6 R5 evict2", 320, 0, 2);
    access("R6 line0 kept", 2, 1, 0);
    step(1'b0, 0);

    // R8: miss saturation, five tags cycling always miss
    step(1'b0, 0, 1'b1);
    for (int i = 0; i < 65540; i++) step(1'b1, (i % 5) * 8);
    chk("R8 miss saturated", miss_cnt_o, 65535);
    chk("R8 hit stays 0", hit_cnt_o, 0);
    chk("R5 cyclic still miss", rsp_hit_o, 0);

    // R8: hit saturation
    step(1'b0, 0, 1'b1);
    step(1'b1, 0);
    for (int i = 0; i < 65540; i++) step(1'b1, 3);
    chk("R8 hit saturated", hit_cnt_o, 65535);
    chk("R8 miss one", miss_cnt_o, 1);
    step(1'b0, 0);
    chk("R7 rsp_valid drops", rsp_valid_o, 0);

    done = 1;
    finish_run();
  end
endmodule